// File: doc/BRIEF.md
# Two-Wire Command Port for a Switch-Matrix Controller

This block is the serial front-end of a switch-matrix controller. It listens on the two open-drain lines of an I2C-compatible bus and runs as a target device. Both lines are sampled on a fast system clock, and START and STOP conditions are found from those samples. The block answers to one 7-bit address, and it acknowledges by pulling the data line low. It gathers a write frame into a two-byte command for the core. For a read frame it shifts out a fixed reply: a zero byte first, then a status byte taken from the core.

The core sees a single-cycle command strobe with the two received bytes. The pad logic sees one pull-down enable for the data line. The block has no matrix state, no clock stretching and no spike filter. The system clock must run at least eight times faster than the bus clock.

Top module: `swx_cmd_port`

## Requirements
- R1: The device address is 7 bits: the upper four bits are fixed at 1110 and the lower three bits come from `dev_pins` (bit 2 first). The address byte carries those 7 bits MSB first, followed by the direction bit. On a match the block drives the data line low during the 9th clock of the address byte.
- R2: If the address does not match, the block does not acknowledge. It then ignores every later byte of that frame, leaving the line released, and waits for the next START.
- R3: A falling data line while SCL is high is a START. A rising data line while SCL is high is a STOP. Data bits are sampled on the rising SCL edge. The pull-down changes only while SCL is low, except when a START or STOP forces it off.
- R4: A direction bit of 0 selects write. The block acknowledges each of the first two data bytes. After the second byte it pulses `cmd_valid_o` for one cycle, with the first byte on `cmd_hi_o` and the second byte on `cmd_lo_o`.
- R5: In a write frame, a third or later data byte is not acknowledged and does not produce another strobe.
- R6: A write frame that stops, or is restarted, before its second data byte produces no strobe.
- R7: A repeated START at any point drops the current frame and begins a new address byte.
- R8: A direction bit of 1 selects read. The block sends 0x00 and then the status byte, each MSB first. A 0 bit is sent by pulling the line low.
- R9: The status byte is captured when the read address byte completes. Changes on `status_i` after that point do not affect the byte that is sent.
- R10: Once the controller does not acknowledge a read byte, the block releases the data line and drives nothing more until the next START.
- R11: While `rst_n` is low, the data line is released and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_pins | input | 3 | Strapped low address bits |
| status_i | input | 8 | Status byte from the core, returned on read |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| cmd_valid_o | output | 1 | One-cycle strobe for a completed write |
| cmd_hi_o | output | 8 | First data byte of the write |
| cmd_lo_o | output | 8 | Second data byte of the write |

## Verification
The bench targets the frame edges where a slave is most likely to go wrong.

- A write that stops after a single byte must not strobe; a design that issues the command on the first byte would produce a spurious command.
- A write that is restarted partway through must resync on the new address; a design that ignores the repeated START would take the new address as data.
- A third data byte must be NACKed; a design that keeps acknowledging would strobe a bogus second command.
- During a read, `status_i` changes after the address byte; a design that samples it late returns the wrong value.
- After the controller's NACK, the data line must be released; a slave that keeps shifting would hold it low and block the STOP.

// File: rtl/swx_pkg.sv
package swx_pkg;
  localparam int BYTE_W     = 8;
  localparam int DATA_BYTES = 2;
  localparam logic [3:0] DEV_ID_HI = 4'b1110;

  typedef enum logic [2:0] {
    FR_IDLE, FR_ADDR, FR_ADDR_ACK, FR_WR, FR_WR_ACK, FR_RD, FR_RD_ACK, FR_SKIP
  } fr_state_t;

  // Device address match: fixed upper nibble plus strapped pins.
  function automatic logic addr_hit(input logic [6:0] rx7, input logic [2:0] pins);
    return rx7 == {DEV_ID_HI, pins};
  endfunction

  // Line level the target must drive for an outgoing bit: pull when bit is 0.
  function automatic logic pull_for_bit(input logic b);
    return !b;
  endfunction
endpackage

// File: rtl/swx_line_sync.sv
module swx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else if (g == 0) begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end else begin
          scl_pipe[g] <= scl_pipe[(g > 0) ? g-1 : 0];
          sda_pipe[g] <= sda_pipe[(g > 0) ? g-1 : 0];
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;
  assign start_evt = scl_s && scl_q && sda_q && !sda_s;
  assign stop_evt  = scl_s && scl_q && !sda_q && sda_s;
endmodule

// File: rtl/swx_frame_ctrl.sv
module swx_frame_ctrl
  import swx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [2:0]        dev_pins,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_pull_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_hi_o,
  output logic [BYTE_W-1:0] cmd_lo_o,
  output logic              mst_nack_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int IDX_W = $clog2(DATA_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(DATA_BYTES);

  fr_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  wr_idx;
  logic              rd_idx;
  logic              ack_seen;
  logic [BYTE_W-1:0] rx_q, tx_q, stat_q, hi_q;
  logic              byte_done;

  assign byte_done  = scl_fall && (cnt == CNT_FULL);
  assign mst_nack_o = (st == FR_RD_ACK) && scl_rise && sda_s && !start_evt && !stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= FR_IDLE;
      cnt         <= '0;
      wr_idx      <= '0;
      rd_idx      <= 1'b0;
      ack_seen    <= 1'b0;
      rx_q        <= '0;
      tx_q        <= '1;
      stat_q      <= '0;
      hi_q        <= '0;
      cmd_valid_o <= 1'b0;
      cmd_hi_o    <= '0;
      cmd_lo_o    <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (start_evt) begin
        st     <= FR_ADDR;
        cnt    <= '0;
        wr_idx <= '0;
        tx_q   <= '1;
      end else if (stop_evt) begin
        st   <= FR_IDLE;
        tx_q <= '1;
      end else begin
        unique case (st)
          FR_ADDR, FR_WR: begin
            if (scl_rise) begin
              rx_q <= {rx_q[BYTE_W-2:0], sda_s};
              cnt  <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt <= '0;
              if (st == FR_ADDR) begin
                if (addr_hit(rx_q[7:1], dev_pins)) begin
                  st     <= FR_ADDR_ACK;
                  rd_idx <= rx_q[0];
                  if (rx_q[0]) stat_q <= status_i;
                end else begin
                  st <= FR_SKIP;
                end
              end else if (wr_idx < IDX_END) begin
                st <= FR_WR_ACK;
                if (wr_idx == '0) hi_q <= rx_q;
                if (wr_idx == IDX_LAST) begin
                  cmd_valid_o <= 1'b1;
                  cmd_hi_o    <= hi_q;
                  cmd_lo_o    <= rx_q;
                end
              end else begin
                st <= FR_SKIP;
              end
            end
          end
          FR_ADDR_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rd_idx) begin
              st     <= FR_RD;
              tx_q   <= '0;
              rd_idx <= 1'b0;
            end else begin
              st     <= FR_WR;
              wr_idx <= '0;
            end
          end
          FR_WR_ACK: if (scl_fall) begin
            st     <= FR_WR;
            wr_idx <= wr_idx + 1'b1;
          end
          FR_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              st   <= FR_RD_ACK;
              tx_q <= '1;
            end else if (scl_fall) begin
              tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
            end
          end
          FR_RD_ACK: begin
            if (scl_rise) begin
              ack_seen <= !sda_s;
              if (sda_s) st <= FR_SKIP;
            end else if (scl_fall && ack_seen) begin
              cnt <= '0;
              if (!rd_idx) begin
                st     <= FR_RD;
                tx_q   <= stat_q;
                rd_idx <= 1'b1;
              end else begin
                st <= FR_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = (st == FR_ADDR_ACK) || (st == FR_WR_ACK) ||
                      ((st == FR_RD) && pull_for_bit(tx_q[BYTE_W-1]));
endmodule

// File: rtl/swx_cmd_port.sv
module swx_cmd_port
  import swx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        dev_pins,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_pull_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_hi_o,
  output logic [BYTE_W-1:0] cmd_lo_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt, mst_nack;

  swx_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  swx_frame_ctrl u_frame (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .dev_pins(dev_pins), .status_i(status_i), .sda_pull_o(sda_pull_o),
    .cmd_valid_o(cmd_valid_o), .cmd_hi_o(cmd_hi_o), .cmd_lo_o(cmd_lo_o),
    .mst_nack_o(mst_nack)
  );
endmodule

// File: rtl/swx_cmd_port_chk.sv
module swx_cmd_port_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_evt,
  input logic stop_evt,
  input logic mst_nack,
  input logic sda_pull,
  input logic cmd_valid
);
  // R11: nothing driven while reset is held
  assert_quiet_in_reset_R11: assert property (@(posedge clk)
    !rst_n |-> (!sda_pull && !cmd_valid));

  // R4: strobe lasts one cycle
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R4: the second data byte is acknowledged together with the strobe
  assert_strobe_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> sda_pull);

  // R3: the pull-down moves only while SCL is low, unless a START or STOP forced it
  assert_pull_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> (!scl_s || $past(start_evt) || $past(stop_evt)));

  // R3: a STOP leaves the line released
  assert_release_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  // R10: controller NACK on read releases the line
  assert_release_on_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mst_nack |=> !sda_pull);
endmodule

bind swx_cmd_port swx_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .mst_nack(mst_nack), .sda_pull(sda_pull_o),
  .cmd_valid(cmd_valid_o)
);

// File: tb/swx_cmd_port_tb.sv
module swx_cmd_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 16;  // system clocks per half bus-clock period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] pins = 3'b101;
  logic [7:0] status = 8'h00;
  logic sda_pull, cmd_valid;
  logic [7:0] cmd_hi, cmd_lo;
  logic sda_bus;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  swx_cmd_port u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .dev_pins(pins), .status_i(status), .sda_pull_o(sda_pull),
    .cmd_valid_o(cmd_valid), .cmd_hi_o(cmd_hi), .cmd_lo_o(cmd_lo)
  );

  // Expected device address, restated from R1
  function automatic logic [6:0] dev_addr(input logic [2:0] p);
    return {4'b1110, p};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(H/2);
    scl_m = 1'b1; wait_clk(H/2);
    sda_m = 1'b0; wait_clk(H/2);
    scl_m = 1'b0; wait_clk(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(H/2);
    scl_m = 1'b1; wait_clk(H/2);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(H/2);
      scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0; wait_clk(H/2);
    end
    sda_m = 1'b1; wait_clk(H/2);
    scl_m = 1'b1; wait_clk(H/2);
    acked = !sda_bus; wait_clk(H/2);
    scl_m = 1'b0; wait_clk(H/2);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wait_clk(H/2);
      scl_m = 1'b1; wait_clk(H/2);
      b = {b[6:0], sda_bus}; wait_clk(H/2);
      scl_m = 1'b0;
    end
    wait_clk(4);
    sda_m = give_ack ? 1'b0 : 1'b1; wait_clk(H/2 - 4);
    scl_m = 1'b1; wait_clk(H);
    scl_m = 1'b0; wait_clk(H/2);
    sda_m = 1'b1;
  endtask

  // Driver: full write frame; pushes expected command when two bytes are acked
  task automatic write_cmd(input logic [6:0] a, input logic [7:0] b0, input logic [7:0] b1,
                           input bit expect_hit);
    bit ak;
    bus_start();
    send_byte({a, 1'b0}, ak);
    chk(ak == expect_hit, expect_hit ? "R1 address ack" : "R2 address nack", 16'(ak), 16'(expect_hit));
    if (expect_hit) exp_q.push_back({b0, b1});
    send_byte(b0, ak);
    chk(ak == expect_hit, expect_hit ? "R4 data0 ack" : "R2 data ignored", 16'(ak), 16'(expect_hit));
    send_byte(b1, ak);
    chk(ak == expect_hit, expect_hit ? "R4 data1 ack" : "R2 data ignored", 16'(ak), 16'(expect_hit));
    bus_stop();
    chk(!sda_pull, "R3 released after stop", 16'(sda_pull), 16'h0);
  endtask

  // Monitor: scoreboard of completed commands
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R5/R6 unexpected strobe", {cmd_hi, cmd_lo}, 16'hxxxx);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({cmd_hi, cmd_lo} == e, "R4 command bytes", {cmd_hi, cmd_lo}, e);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    bit ak;
    logic [7:0] rb;
    wait_clk(5);
    chk(!sda_pull && !cmd_valid, "R11 reset state", {sda_pull, cmd_valid}, 16'h0);
    rst_n = 1'b1;
    wait_clk(10);

    // R1/R4: matching write
    write_cmd(dev_addr(pins), 8'h5A, 8'hC3, 1'b1);
    // R2: low bits differ
    write_cmd(dev_addr(3'b100), 8'h11, 8'h22, 1'b0);
    // R1: upper nibble differs
    write_cmd({4'b0110, pins}, 8'h33, 8'h44, 1'b0);

    // R6: write ends after one byte
    bus_start();
    send_byte({dev_addr(pins), 1'b0}, ak);
    chk(ak, "R6 address ack", 16'(ak), 16'h1);
    send_byte(8'h77, ak);
    chk(ak, "R6 single byte ack", 16'(ak), 16'h1);
    bus_stop();
    wait_clk(4 * H);

    // R7/R6: repeated START after one data byte, then a full write
    bus_start();
    send_byte({dev_addr(pins), 1'b0}, ak);
    send_byte(8'h99, ak);
    bus_start();
    send_byte({dev_addr(pins), 1'b0}, ak);
    chk(ak, "R7 address after restart", 16'(ak), 16'h1);
    exp_q.push_back(16'h1234);
    send_byte(8'h12, ak);
    send_byte(8'h34, ak);
    chk(ak, "R7 second byte after restart", 16'(ak), 16'h1);
    bus_stop();

    // R5: third data byte refused
    bus_start();
    send_byte({dev_addr(pins), 1'b0}, ak);
    exp_q.push_back(16'hABCD);
    send_byte(8'hAB, ak);
    send_byte(8'hCD, ak);
    send_byte(8'hEF, ak);
    chk(!ak, "R5 third byte nack", 16'(ak), 16'h0);
    bus_stop();

    // R8/R9/R10: read, status changes after the address byte
    status = 8'hA5;
    bus_start();
    send_byte({dev_addr(pins), 1'b1}, ak);
    chk(ak, "R1 read address ack", 16'(ak), 16'h1);
    status = 8'h3C;
    recv_byte(1'b1, rb);
    chk(rb == 8'h00, "R8 dummy byte", 16'(rb), 16'h00);
    recv_byte(1'b0, rb);
    chk(rb == 8'hA5, "R9 captured status", 16'(rb), 16'hA5);
    wait_clk(H/2);
    chk(!sda_pull, "R10 released after nack", 16'(sda_pull), 16'h0);
    bus_stop();

    // R8: second read with a different status pattern
    bus_start();
    send_byte({dev_addr(pins), 1'b1}, ak);
    recv_byte(1'b1, rb);
    chk(rb == 8'h00, "R8 dummy byte again", 16'(rb), 16'h00);
    recv_byte(1'b0, rb);
    chk(rb == 8'h3C, "R8 status byte", 16'(rb), 16'h3C);
    bus_stop();

    // R2: read to another address is ignored
    bus_start();
    send_byte({dev_addr(3'b000), 1'b1}, ak);
    chk(!ak, "R2 read address nack", 16'(ak), 16'h0);
    recv_byte(1'b0, rb);
    chk(rb == 8'hFF, "R2 line left released", 16'(rb), 16'hFF);
    bus_stop();

    // R1: new strap value
    pins = 3'b010;
    wait_clk(H);
    write_cmd(dev_addr(3'b010), 8'h0F, 8'hF0, 1'b1);
    write_cmd(dev_addr(3'b101), 8'h55, 8'hAA, 1'b0);

    wait_clk(4 * H);
    chk(exp_q.size() == 0, "R4 all commands seen", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule